// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block is the digital divider network behind a clock distribution device. One of two clocks feeds it: a fast clock from the on-chip oscillator, or an external reference that can replace the oscillator when the loop is bypassed. An optional common divide-by-two stage follows. Three output banks come after that, with five, four and two outputs. Each bank picks one of two divide ratios. Every ratio gives an exact 50% duty cycle counted in source-clock cycles, and this includes divide-by-six.

A single active-high input does two jobs: it resets the dividers and it disables the outputs. While it is high, the block samples the ratio and prescale selects, clears every divider, drops the pad drive enable and parks all data outputs low. On the first source-clock edge after it falls, every bank output and the pad enable rise together. From then on the banks run phase-aligned from that common start.

The data outputs and `pad_oe` are meant for the pad ring. The pad buffer puts a pin in high impedance whenever `pad_oe` is low. Every input is active high, so tying all of them low selects the oscillator, no prescale, bank A divide-by-4, bank B divide-by-4, bank C divide-by-2, with outputs enabled.

Top module: `mbclk_divider`

## Requirements
- R1: `bypass_sel` low clocks all logic from `clk_fast`; `bypass_sel` high clocks it from `clk_ref` instead. The source is changed only while `rst_oe` is high.
- R2: With `half_rate` high (as sampled in reset), a bank output changes on at most every second source edge, and each bank's period becomes twice its ratio in source cycles.
- R3: Bank A (`bank_a_q`, 5 bits) divides by 4 when `sel_a` is 0 and by 6 when it is 1. All five bits are identical.
- R4: Bank B (`bank_b_q`, 4 bits) divides by 4 when `sel_b` is 0 and by 2 when it is 1. All four bits are identical.
- R5: Bank C (`bank_c_q`, 2 bits) divides by 2 when `sel_c` is 0 and by 4 when it is 1. Both bits are identical.
- R6: On every source edge where `rst_oe` is sampled high, `pad_oe` and every data output become 0.
- R7: Number the source edges after `rst_oe` falls k = 0, 1, 2, …, and let n = k+1 without prescale or n = k/2+1 with prescale. A bank with ratio N is 1 when ((n-1) mod N) < N/2, and `pad_oe` is 1. So all banks rise together at k = 0, and each output is high for exactly half of its period.
- R8: Changes to `half_rate`, `sel_a`, `sel_b` or `sel_c` while `rst_oe` is low have no effect until the next reset.
- R9: The block is fully static. If the source clock stops, the outputs hold their levels, and they continue the sequence of R7 when the clock resumes.
- R10: With every control input at 0, the outputs follow R7 with the oscillator as source, no prescale, and ratios 4, 4 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock, the normal source |
| clk_ref | input | 1 | Reference clock used in bypass |
| bypass_sel | input | 1 | 1 selects `clk_ref` as the source |
| half_rate | input | 1 | 1 inserts the common divide-by-two |
| sel_a | input | 1 | Bank A ratio: 0 → 4, 1 → 6 |
| sel_b | input | 1 | Bank B ratio: 0 → 4, 1 → 2 |
| sel_c | input | 1 | Bank C ratio: 0 → 2, 1 → 4 |
| rst_oe | input | 1 | 1 resets dividers, latches selects, disables pads |
| pad_oe | output | 1 | Pad drive enable; 0 means high impedance |
| bank_a_q | output | 5 | Bank A clock outputs |
| bank_b_q | output | 4 | Bank B clock outputs |
| bank_c_q | output | 2 | Bank C clock outputs |

## Verification
The bench predicts every output on every source edge for all ratio pairs, with and without prescale, on both sources. A divide-by-six that splits its period unevenly, or a counter that starts at the wrong phase, would miscompare at the first fall, and a bank that misses the common first rise would miscompare at k = 0. The selects and the prescale input are flipped in the middle of a run. A design that reads them live would change ratio at once and break the predicted sequence. The reference clock is also stopped for a long stretch and then restarted. A divider with any timed or self-clearing behaviour would drift or restart, so its outputs would differ from the held values or from the continued sequence.

// File: rtl/mbclk_pkg.sv
package mbclk_pkg;

  // Configuration captured while the block is held in reset.
  typedef struct packed {
    logic pre;    // common divide-by-two enabled
    logic a_alt;  // bank A uses its alternate ratio
    logic b_alt;  // bank B uses its alternate ratio
    logic c_alt;  // bank C uses its alternate ratio
  } mbclk_cfg_t;

  localparam mbclk_cfg_t MBCLK_CFG_DEFAULT = '{pre: 1'b0, a_alt: 1'b0, b_alt: 1'b0, c_alt: 1'b0};

  function automatic int unsigned max2(input int unsigned x, input int unsigned y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/mbclk_src_mux.sv
module mbclk_src_mux (
  input  logic clk_fast,
  input  logic clk_ref,
  input  logic use_ref,
  output logic src_clk
);

  // Maps to a dedicated global clock multiplexer on the target.
  // The select only moves while the dividers are held in reset.
  assign src_clk = use_ref ? clk_ref : clk_fast;

endmodule

// File: rtl/mbclk_ctrl.sv
module mbclk_ctrl
  import mbclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_oe,
  input  logic       pre_in,
  input  logic       a_in,
  input  logic       b_in,
  input  logic       c_in,
  output mbclk_cfg_t cfg_q,
  output logic       tick,
  output logic       oe_q
);

  logic phase_q;

  // Selects are transparent only during reset; frozen while running.
  always_ff @(posedge clk) begin
    if (rst_oe) begin
      cfg_q <= '{pre: pre_in, a_alt: a_in, b_alt: b_in, c_alt: c_in};
    end
  end

  // Pad enable: registered so it moves on the same edge as the data outputs.
  always_ff @(posedge clk) begin
    if (rst_oe) oe_q <= 1'b0;
    else        oe_q <= 1'b1;
  end

  // Prescale phase: alternate edges when enabled, every edge otherwise.
  always_ff @(posedge clk) begin
    if (rst_oe)         phase_q <= 1'b0;
    else if (cfg_q.pre) phase_q <= ~phase_q;
    else                phase_q <= 1'b0;
  end

  // The first edge after release is always an active one for every bank.
  assign tick = ~phase_q;

endmodule

// File: rtl/mbclk_bank_div.sv
module mbclk_bank_div
  import mbclk_pkg::*;
#(
  parameter int unsigned NOUT      = 4,
  parameter int unsigned RATIO_DEF = 4,
  parameter int unsigned RATIO_ALT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            alt,
  output logic [NOUT-1:0] q
);

  localparam int unsigned HALF_DEF = RATIO_DEF / 2;
  localparam int unsigned HALF_ALT = RATIO_ALT / 2;
  localparam int unsigned HALF_MAX = max2(HALF_DEF, HALF_ALT);
  localparam int unsigned CW       = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
  localparam logic [CW-1:0] RELOAD_DEF = CW'(HALF_DEF - 1);
  localparam logic [CW-1:0] RELOAD_ALT = CW'(HALF_ALT - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic [CW-1:0] reload;

  assign reload = alt ? RELOAD_ALT : RELOAD_DEF;

  // Down-counter over half periods; the level flips on each expiry,
  // so high and low phases always span the same number of ticks.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        level_q <= ~level_q;
        cnt_q   <= reload;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // All outputs of the bank come from one register.
  for (genvar gi = 0; gi < NOUT; gi++) begin : g_fanout
    assign q[gi] = level_q;
  end

endmodule

// File: rtl/mbclk_divider.sv
module mbclk_divider
  import mbclk_pkg::*;
#(
  parameter int unsigned NA      = 5,
  parameter int unsigned NB      = 4,
  parameter int unsigned NC      = 2,
  parameter int unsigned A_DEF   = 4,
  parameter int unsigned A_ALT   = 6,
  parameter int unsigned B_DEF   = 4,
  parameter int unsigned B_ALT   = 2,
  parameter int unsigned C_DEF   = 2,
  parameter int unsigned C_ALT   = 4
) (
  input  logic          clk_fast,
  input  logic          clk_ref,
  input  logic          bypass_sel,
  input  logic          half_rate,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          sel_c,
  input  logic          rst_oe,
  output logic          pad_oe,
  output logic [NA-1:0] bank_a_q,
  output logic [NB-1:0] bank_b_q,
  output logic [NC-1:0] bank_c_q
);

  logic       src_clk;
  mbclk_cfg_t cfg_q;
  logic       tick;

  mbclk_src_mux u_src (
    .clk_fast (clk_fast),
    .clk_ref  (clk_ref),
    .use_ref  (bypass_sel),
    .src_clk  (src_clk)
  );

  mbclk_ctrl u_ctrl (
    .clk    (src_clk),
    .rst_oe (rst_oe),
    .pre_in (half_rate),
    .a_in   (sel_a),
    .b_in   (sel_b),
    .c_in   (sel_c),
    .cfg_q  (cfg_q),
    .tick   (tick),
    .oe_q   (pad_oe)
  );

  mbclk_bank_div #(.NOUT(NA), .RATIO_DEF(A_DEF), .RATIO_ALT(A_ALT)) u_bank_a (
    .clk  (src_clk),
    .rst  (rst_oe),
    .tick (tick),
    .alt  (cfg_q.a_alt),
    .q    (bank_a_q)
  );

  mbclk_bank_div #(.NOUT(NB), .RATIO_DEF(B_DEF), .RATIO_ALT(B_ALT)) u_bank_b (
    .clk  (src_clk),
    .rst  (rst_oe),
    .tick (tick),
    .alt  (cfg_q.b_alt),
    .q    (bank_b_q)
  );

  mbclk_bank_div #(.NOUT(NC), .RATIO_DEF(C_DEF), .RATIO_ALT(C_ALT)) u_bank_c (
    .clk  (src_clk),
    .rst  (rst_oe),
    .tick (tick),
    .alt  (cfg_q.c_alt),
    .q    (bank_c_q)
  );

endmodule

// File: rtl/mbclk_divider_chk.sv
module mbclk_divider_chk #(
  parameter int unsigned NA = 5,
  parameter int unsigned NB = 4,
  parameter int unsigned NC = 2
) (
  input logic          src_clk,
  input logic          rst_oe,
  input logic          pad_oe,
  input logic [NA-1:0] bank_a_q,
  input logic [NB-1:0] bank_b_q,
  input logic [NC-1:0] bank_c_q,
  input logic          cfg_pre,
  input logic          cfg_c_alt
);

  // R6: once released, the pad enable stays up until the next reset
  p_enable_held_r6: assert property (@(posedge src_clk) disable iff (rst_oe)
    !rst_oe |=> pad_oe);

  // R7: the edge that raises the pad enable also raises every bank
  p_common_first_rise_r7: assert property (@(posedge src_clk) disable iff (rst_oe)
    $rose(pad_oe) |-> ((&bank_a_q) && (&bank_b_q) && (&bank_c_q)));

  // R5: bank C at its default ratio without prescale toggles on every edge
  p_c_every_edge_r5: assert property (@(posedge src_clk) disable iff (rst_oe)
    (pad_oe && !cfg_pre && !cfg_c_alt) |=> (bank_c_q[0] != $past(bank_c_q[0])));

  // R2: with prescale, an output change is never followed by another on the next edge
  p_prescaled_hold_r2: assert property (@(posedge src_clk) disable iff (rst_oe)
    (pad_oe && cfg_pre && !$stable(bank_c_q[0])) |=> $stable(bank_c_q[0]));

  // R2: same for bank A
  p_prescaled_hold_a_r2: assert property (@(posedge src_clk) disable iff (rst_oe)
    (pad_oe && cfg_pre && !$stable(bank_a_q[0])) |=> $stable(bank_a_q[0]));

endmodule

bind mbclk_divider mbclk_divider_chk #(.NA(NA), .NB(NB), .NC(NC)) i_chk (
  .src_clk   (src_clk),
  .rst_oe    (rst_oe),
  .pad_oe    (pad_oe),
  .bank_a_q  (bank_a_q),
  .bank_b_q  (bank_b_q),
  .bank_c_q  (bank_c_q),
  .cfg_pre   (cfg_q.pre),
  .cfg_c_alt (cfg_q.c_alt)
);

// File: tb/test_mbclk_divider.sv
module test_mbclk_divider;

  logic clk_fast = 1'b0;
  logic clk_ref  = 1'b0;
  logic ref_run  = 1'b1;
  logic bypass_sel = 1'b0;
  logic half_rate  = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
  logic rst_oe = 1'b1;
  logic       pad_oe;
  logic [4:0] bank_a_q;
  logic [3:0] bank_b_q;
  logic [1:0] bank_c_q;
  logic       src_b;

  int vectors = 0;
  int miscompares = 0;

  logic [11:0] exq[$];
  string       tagq[$];

  // Scenario state
  bit g_pre;
  int g_ra, g_rb, g_rc, g_k;

  always #10 clk_fast = ~clk_fast;           // 50 MHz
  always begin #35; if (ref_run) clk_ref = ~clk_ref; end

  assign src_b = bypass_sel ? clk_ref : clk_fast;

  mbclk_divider i_mbclk_divider (
    .clk_fast   (clk_fast),
    .clk_ref    (clk_ref),
    .bypass_sel (bypass_sel),
    .half_rate  (half_rate),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .sel_c      (sel_c),
    .rst_oe     (rst_oe),
    .pad_oe     (pad_oe),
    .bank_a_q   (bank_a_q),
    .bank_b_q   (bank_b_q),
    .bank_c_q   (bank_c_q)
  );

  function automatic logic lvl(input int k, input bit pre, input int r);
    int n;
    n = pre ? (k / 2 + 1) : (k + 1);
    return ((n - 1) % r) < (r / 2);
  endfunction

  // Monitor: pop one expectation per source edge, after the registers settle.
  always begin
    @(posedge src_b);
    #2;
    if (exq.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exq.pop_front();
      t = tagq.pop_front();
      vectors++;
      if ({pad_oe, bank_a_q, bank_b_q, bank_c_q} !== e) begin
        miscompares++;
        $display("FAIL %s: got oe=%b a=%b b=%b c=%b, expected oe=%b a=%b b=%b c=%b",
                 t, pad_oe, bank_a_q, bank_b_q, bank_c_q, e[11], e[10:6], e[5:2], e[1:0]);
      end
    end
  end

  task automatic push_item(input logic [11:0] e, input string t);
    exq.push_back(e);
    tagq.push_back(t);
  endtask

  // Driver: reset with a configuration, then release.
  task automatic start_cfg(input bit byp, input bit pre, input bit sa, input bit sb,
                           input bit sc);
    bit same_src;
    same_src = (byp == bypass_sel);
    rst_oe = 1'b1;
    bypass_sel = byp; half_rate = pre; sel_a = sa; sel_b = sb; sel_c = sc;
    if (same_src) push_item(12'h000, "R6");   // reset from a running state
    @(negedge src_b);
    for (int i = 0; i < 3; i++) begin
      push_item(12'h000, "R6");
      @(negedge src_b);
    end
    g_pre = pre;
    g_ra = sa ? 6 : 4;
    g_rb = sb ? 2 : 4;
    g_rc = sc ? 4 : 2;
    g_k = 0;
    rst_oe = 1'b0;
  endtask

  task automatic run_more(input int ncyc, input string t);
    for (int i = 0; i < ncyc; i++) begin
      logic a, b, c;
      a = lvl(g_k, g_pre, g_ra);
      b = lvl(g_k, g_pre, g_rb);
      c = lvl(g_k, g_pre, g_rc);
      push_item({1'b1, {5{a}}, {4{b}}, {2{c}}}, t);
      g_k++;
      @(negedge src_b);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #3_000_000;
    vectors++;
    miscompares++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] snap;
    repeat (2) @(negedge clk_fast);

    // R10: all-zero controls, default ratios from the oscillator
    start_cfg(0, 0, 0, 0, 0);
    run_more(16, "R10");

    // R3: bank A divide-by-6 (sel_a=1)
    start_cfg(0, 0, 1, 0, 0);
    run_more(24, "R3");

    // R4: bank B divide-by-2 (sel_b=1)
    start_cfg(0, 0, 0, 1, 0);
    run_more(12, "R4");

    // R5: bank C divide-by-4 (sel_c=1)
    start_cfg(0, 0, 0, 0, 1);
    run_more(12, "R5");

    // R7: mixed ratios 6/2/2, common first rise and alignment
    start_cfg(0, 0, 1, 1, 0);
    run_more(26, "R7");

    // R2: prescale with default and alternate ratios
    start_cfg(0, 1, 0, 0, 0);
    run_more(30, "R2");
    start_cfg(0, 1, 1, 1, 1);
    run_more(30, "R2");

    // R8: flip every select mid-run; the sequence must not change
    start_cfg(0, 0, 0, 0, 0);
    run_more(10, "R8");
    half_rate = 1'b1; sel_a = 1'b1; sel_b = 1'b1; sel_c = 1'b1;
    run_more(20, "R8");

    // R1: bypass to the reference clock
    start_cfg(1, 0, 1, 0, 1);
    run_more(10, "R1");

    // R9: stop the reference clock, outputs must hold, then resume
    ref_run = 1'b0;
    snap = {pad_oe, bank_a_q, bank_b_q, bank_c_q};
    #700;
    vectors++;
    if ({pad_oe, bank_a_q, bank_b_q, bank_c_q} !== snap) begin
      miscompares++;
      $display("FAIL R9: got %b, expected held %b", {pad_oe, bank_a_q, bank_b_q, bank_c_q}, snap);
    end
    ref_run = 1'b1;
    run_more(14, "R9");

    // R1: bypass with prescale
    start_cfg(1, 1, 0, 1, 0);
    run_more(20, "R1");

    // back to the oscillator, R6 reset once more
    start_cfg(0, 0, 0, 0, 0);
    run_more(4, "R10");
    rst_oe = 1'b1;
    push_item(12'h000, "R6");
    @(negedge src_b);
    push_item(12'h000, "R6");
    @(negedge src_b);

    repeat (2) @(negedge src_b);
    summary();
    $finish;
  end

endmodule